// File: doc/BRIEF.md
# System Reset Sequencing Controller

This block decides when the core of a small microcontroller, and separately its on-chip debug logic, are held in reset. It collects reset requests from a supply-good indication, a watchdog time-out, an active-low external reset pin, a debugger control bit and an active-low debug pin. It accepts only the requests that are valid in the current operating mode, which is either run (normal or halt) or stop. Both pins pass through a two-stage synchronizer and a minimum-width filter, so short glitches are dropped.

When supply-good rises, a power-on delay counter must expire before the core is released. The length of that delay depends on whether the option setting selects the crystal oscillator. Any other accepted source keeps the core in reset for as long as it is present. After the source goes away, the reset is held for a fixed stretch before release. A reset started only by the debugger bit leaves the debug logic running.

Three status flags record the cause of a reset: power-on, watchdog and external pin. Software clears each flag by writing one to it. A power-on event clears all flags and the debugger bit.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `supply_ok` is low, `core_rst_n`, `dbg_rst_n`, `por_flag`, `wdt_flag`, `ext_flag` and `dbg_ctl_bit` are all 0 at once, without waiting for a clock edge.
- R2: With `xtal_sel` = 0, `core_rst_n` rises after the INT_CYC+3rd rising edge following the rise of `supply_ok`. The count is two edges of reset synchronization, INT_CYC counted cycles and one release edge. `core_rst_n` is still 0 after the edge before that one.
- R3: With `xtal_sel` = 1, the same rule as R2 applies with XTAL_CYC in place of INT_CYC.
- R4: `por_flag` becomes 1 on the same edge on which `core_rst_n` leaves the power-on reset. A one-cycle pulse on `clr_por_flag` clears it.
- R5: Count the first rising edge that samples `ext_rst_n` low as edge 1. A low level on `ext_rst_n` that spans 3 or more consecutive rising edges drives `core_rst_n` to 0 after edge 6. A low level that spans fewer than 3 edges leaves `core_rst_n` at 1. This holds in both modes.
- R6: Once an accepted source goes away, the reset is held for a further STRETCH_CYC cycles. For a pin held low for N ≥ 3 edges, `core_rst_n` is 0 after edges 6 through N+18 and is 1 again after edge N+19 (STRETCH_CYC = 16). For a one-cycle request seen at edge A, `core_rst_n` is 0 after edges A through A+15.
- R7: A `wdt_timeout` pulse resets the core only in run mode (`mode_stop` = 0) and only with `wdt_rst_en` = 1. In every other combination it has no effect on `core_rst_n`.
- R8: A pulse on `dbg_ctl_wr` sets `dbg_ctl_bit` on the next edge. In run mode the bit starts a reset on the following edge and clears itself on that same edge. `dbg_rst_n` stays 1 throughout that reset. In stop mode the bit stays pending and causes no reset until run mode returns.
- R9: In stop mode, a low level on `dbg_pin_n` follows the same filter and timing as R5/R6 and drives both `core_rst_n` and `dbg_rst_n` low. In run mode `dbg_pin_n` has no effect.
- R10: `dbg_rst_n` goes low together with `core_rst_n` for external-pin, debug-pin and watchdog resets. If such a source arrives during a reset started by the debugger bit, `dbg_rst_n` falls on the edge where that source is seen.
- R11: `wdt_flag` and `ext_flag` set when their source is accepted and clear on a one-cycle pulse of their clear input. When a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| supply_ok | input | 1 | Qualified supply-good; low is the power-on/brown-out reset |
| xtal_sel | input | 1 | Option setting: 1 selects the crystal oscillator (long delay) |
| mode_stop | input | 1 | 1 = stop mode, 0 = run (normal/halt) mode |
| wdt_timeout | input | 1 | Watchdog time-out pulse |
| wdt_rst_en | input | 1 | Watchdog configured to reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| dbg_pin_n | input | 1 | Debug pin, active low, asynchronous |
| dbg_ctl_wr | input | 1 | Debugger write of one to the reset control bit |
| clr_por_flag | input | 1 | Write-one-to-clear for the power-on flag |
| clr_wdt_flag | input | 1 | Write-one-to-clear for the watchdog flag |
| clr_ext_flag | input | 1 | Write-one-to-clear for the external-pin flag |
| core_rst_n | output | 1 | Core reset, active low |
| dbg_rst_n | output | 1 | Debug-logic reset, active low |
| por_flag | output | 1 | Power-on reset occurred |
| wdt_flag | output | 1 | Watchdog reset occurred |
| ext_flag | output | 1 | External-pin reset occurred |
| dbg_ctl_bit | output | 1 | Debugger reset control bit |

## Verification
Every result has a fixed latency, and the bench derives each latency from the register chain. The power-on release comes INT_CYC+3 or XTAL_CYC+3 edges after supply-good rises. A pin reset starts 6 edges after the pin is first sampled low, and the debugger bit 2 edges after its write. A one-cycle watchdog request takes effect on the very edge that samples it. Each release comes STRETCH_CYC edges after the last edge that still saw a request. The bench drives and samples only at falling edges and counts rising edges from the stimulus. Sweeps over pin widths, modes and enables compare both reset outputs against the computed window on every cycle.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

  // Operating mode as seen by the source qualification logic.
  typedef enum logic {
    RUN_MODE  = 1'b0,
    STOP_MODE = 1'b1
  } op_mode_e;

  // Qualified reset requests, one bit per source.
  typedef struct packed {
    logic wdt;
    logic ext;
    logic ocd;
    logic dpin;
  } rst_req_t;

  // Index of each filtered pin in the filter array.
  localparam int unsigned PIN_EXT  = 0;
  localparam int unsigned PIN_DBG  = 1;
  localparam int unsigned NUM_PINS = 2;

endpackage

// File: rtl/rstc_rst_sync.sv
module rstc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_WIDTH   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic valid
);

  localparam int unsigned CW = $clog2(MIN_WIDTH + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic [CW-1:0]          cnt_q;
  logic [CW-1:0]          cnt_d;
  logic                   asserted;

  assign asserted = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ~pin_n};
    if (!asserted) begin
      cnt_d = '0;
    end else if (cnt_q != CW'(MIN_WIDTH)) begin
      cnt_d = cnt_q + CW'(1);
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  assign valid = (cnt_q == CW'(MIN_WIDTH));

  // R5: a request only appears after a full run of asserted samples
  a_r5_width_reached: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> ($past(cnt_q) == CW'(MIN_WIDTH - 1)) && $past(asserted));

  // R5: a released pin withdraws the request on the next edge
  a_r5_drop_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !asserted |=> !valid);

endmodule

// File: rtl/rstc_por_timer.sv
module rstc_por_timer #(
  parameter int unsigned INT_CYC  = 64,
  parameter int unsigned XTAL_CYC = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xtal_sel,
  output logic done,
  output logic done_set
);

  localparam int unsigned MAXC = (XTAL_CYC > INT_CYC) ? XTAL_CYC : INT_CYC;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic [CW-1:0] limit;
  logic          done_q;
  logic          done_d;
  logic          term;

  always_comb begin
    limit    = xtal_sel ? CW'(XTAL_CYC) : CW'(INT_CYC);
    term     = (cnt_q >= limit);
    cnt_d    = (!done_q && !term) ? cnt_q + CW'(1) : cnt_q;
    done_d   = done_q | term;
    done_set = term & ~done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign done = done_q;

  // R2: once released, the power-on stage never re-enters reset without supply loss
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);

  // R3: release only after the selected count has been reached
  a_r3_limit_reached: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(cnt_q) >= $past(limit)));

endmodule

// File: rtl/rstc_hold_ctrl.sv
module rstc_hold_ctrl
  import rstc_pkg::*;
#(
  parameter int unsigned STRETCH_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic mode_stop,
  input  logic wdt_timeout,
  input  logic wdt_rst_en,
  input  logic ext_valid,
  input  logic dpin_valid,
  input  logic ctl_bit,
  output logic hold,
  output logic spare_dbg,
  output logic req_wdt,
  output logic req_ext,
  output logic req_ocd
);

  localparam int unsigned CW = $clog2(STRETCH_CYC + 1);

  op_mode_e      mode;
  rst_req_t      req;
  logic          any_req;
  logic          non_ocd;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          hold_q;
  logic          hold_d;
  logic          spare_q;
  logic          spare_d;

  assign mode = op_mode_e'(mode_stop);

  // Source qualification by operating mode
  always_comb begin
    req.wdt  = arm && (mode == RUN_MODE) && wdt_timeout && wdt_rst_en;
    req.ext  = arm && ext_valid;
    req.ocd  = arm && (mode == RUN_MODE) && ctl_bit;
    req.dpin = arm && (mode == STOP_MODE) && dpin_valid;
    any_req  = |req;
    non_ocd  = req.wdt | req.ext | req.dpin;
  end

  // Stretch counter and debug-spare tracking
  always_comb begin
    if (any_req) begin
      cnt_d = CW'(STRETCH_CYC);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end else begin
      cnt_d = cnt_q;
    end
    hold_d = any_req | (cnt_q > CW'(1));
    if (any_req) begin
      spare_d = (hold_q ? spare_q : 1'b1) & ~non_ocd;
    end else begin
      spare_d = spare_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      hold_q  <= 1'b0;
      spare_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      hold_q  <= hold_d;
      spare_q <= spare_d;
    end
  end

  assign hold      = hold_q;
  assign spare_dbg = spare_q;
  assign req_wdt   = req.wdt;
  assign req_ext   = req.ext;
  assign req_ocd   = req.ocd;

  // R6: an accepted request holds the core on the next edge
  a_r6_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> hold_q);

  // R6: release never happens on an edge that still saw a request
  a_r6_no_early_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> !$past(any_req));

  // R7: in stop mode only the pins can start a reset
  a_r7_stop_ignores_wdt: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_stop && !ext_valid && !dpin_valid && !hold_q) |=> !hold_q);

  // R9: in run mode the debug pin cannot start a reset
  a_r9_run_ignores_dpin: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_stop && !ext_valid && !wdt_timeout && !ctl_bit && !hold_q) |=> !hold_q);

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rstc_pkg::*;
#(
  parameter int unsigned INT_CYC       = 64,
  parameter int unsigned XTAL_CYC      = 4096,
  parameter int unsigned STRETCH_CYC   = 16,
  parameter int unsigned PIN_MIN_WIDTH = 3,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic supply_ok,
  input  logic xtal_sel,
  input  logic mode_stop,
  input  logic wdt_timeout,
  input  logic wdt_rst_en,
  input  logic ext_rst_n,
  input  logic dbg_pin_n,
  input  logic dbg_ctl_wr,
  input  logic clr_por_flag,
  input  logic clr_wdt_flag,
  input  logic clr_ext_flag,
  output logic core_rst_n,
  output logic dbg_rst_n,
  output logic por_flag,
  output logic wdt_flag,
  output logic ext_flag,
  output logic dbg_ctl_bit
);

  logic                rst_n;
  logic [NUM_PINS-1:0] pins_n;
  logic [NUM_PINS-1:0] pin_valid;
  logic                por_done;
  logic                por_set;
  logic                hold;
  logic                spare_dbg;
  logic                req_wdt;
  logic                req_ext;
  logic                req_ocd;

  logic ctl_q, ctl_d;
  logic por_flag_q, por_flag_d;
  logic wdt_flag_q, wdt_flag_d;
  logic ext_flag_q, ext_flag_d;

  // Supply-good is asserted asynchronously and released synchronously
  rstc_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk    (clk),
    .arst_n (supply_ok),
    .srst_n (rst_n)
  );

  assign pins_n[PIN_EXT] = ext_rst_n;
  assign pins_n[PIN_DBG] = dbg_pin_n;

  for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_pin
    rstc_pin_filter #(
      .SYNC_STAGES (SYNC_STAGES),
      .MIN_WIDTH   (PIN_MIN_WIDTH)
    ) u_filt (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_n (pins_n[gi]),
      .valid (pin_valid[gi])
    );
  end

  rstc_por_timer #(
    .INT_CYC  (INT_CYC),
    .XTAL_CYC (XTAL_CYC)
  ) u_por (
    .clk      (clk),
    .rst_n    (rst_n),
    .xtal_sel (xtal_sel),
    .done     (por_done),
    .done_set (por_set)
  );

  rstc_hold_ctrl #(
    .STRETCH_CYC (STRETCH_CYC)
  ) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (por_done),
    .mode_stop   (mode_stop),
    .wdt_timeout (wdt_timeout),
    .wdt_rst_en  (wdt_rst_en),
    .ext_valid   (pin_valid[PIN_EXT]),
    .dpin_valid  (pin_valid[PIN_DBG]),
    .ctl_bit     (ctl_q),
    .hold        (hold),
    .spare_dbg   (spare_dbg),
    .req_wdt     (req_wdt),
    .req_ext     (req_ext),
    .req_ocd     (req_ocd)
  );

  // Debugger control bit and status flags: set has priority over clear
  always_comb begin
    if (dbg_ctl_wr) begin
      ctl_d = 1'b1;
    end else if (req_ocd) begin
      ctl_d = 1'b0;
    end else begin
      ctl_d = ctl_q;
    end
    por_flag_d = por_set | (por_flag_q & ~clr_por_flag);
    wdt_flag_d = req_wdt | (wdt_flag_q & ~clr_wdt_flag);
    ext_flag_d = req_ext | (ext_flag_q & ~clr_ext_flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= 1'b0;
      por_flag_q <= 1'b0;
      wdt_flag_q <= 1'b0;
      ext_flag_q <= 1'b0;
    end else begin
      ctl_q      <= ctl_d;
      por_flag_q <= por_flag_d;
      wdt_flag_q <= wdt_flag_d;
      ext_flag_q <= ext_flag_d;
    end
  end

  assign core_rst_n  = por_done & ~hold;
  assign dbg_rst_n   = por_done & ~(hold & ~spare_dbg);
  assign por_flag    = por_flag_q;
  assign wdt_flag    = wdt_flag_q;
  assign ext_flag    = ext_flag_q;
  assign dbg_ctl_bit = ctl_q;

  // R4: the power-on flag is set on the release edge
  a_r4_por_flag_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_done) |-> por_flag_q);

  // R8: in run mode a pending debugger bit is consumed on the next edge
  a_r8_ctl_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q && !mode_stop && por_done && !dbg_ctl_wr) |=> !ctl_q);

  // R8: a reset started by the debugger bit leaves the debug logic running
  a_r8_ocd_spares_dbg: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ocd && !hold && !req_wdt && !req_ext && !mode_stop) |=> dbg_rst_n);

  // R11: a source seen on an edge sets its flag even with a clear
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wdt || req_ext) |=> (wdt_flag_q || ext_flag_q));

endmodule

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;

  localparam int INT_C  = 10;
  localparam int XTAL_C = 24;
  localparam int STR_C  = 16;

  logic clk;
  logic supply_ok, xtal_sel, mode_stop, wdt_timeout, wdt_rst_en;
  logic ext_rst_n, dbg_pin_n, dbg_ctl_wr;
  logic clr_por_flag, clr_wdt_flag, clr_ext_flag;
  logic core_rst_n, dbg_rst_n, por_flag, wdt_flag, ext_flag, dbg_ctl_bit;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  rst_seq_ctrl #(
    .INT_CYC       (INT_C),
    .XTAL_CYC      (XTAL_C),
    .STRETCH_CYC   (STR_C),
    .PIN_MIN_WIDTH (3),
    .SYNC_STAGES   (2)
  ) dut_i (
    .clk          (clk),
    .supply_ok    (supply_ok),
    .xtal_sel     (xtal_sel),
    .mode_stop    (mode_stop),
    .wdt_timeout  (wdt_timeout),
    .wdt_rst_en   (wdt_rst_en),
    .ext_rst_n    (ext_rst_n),
    .dbg_pin_n    (dbg_pin_n),
    .dbg_ctl_wr   (dbg_ctl_wr),
    .clr_por_flag (clr_por_flag),
    .clr_wdt_flag (clr_wdt_flag),
    .clr_ext_flag (clr_ext_flag),
    .core_rst_n   (core_rst_n),
    .dbg_rst_n    (dbg_rst_n),
    .por_flag     (por_flag),
    .wdt_flag     (wdt_flag),
    .ext_flag     (ext_flag),
    .dbg_ctl_bit  (dbg_ctl_bit)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic release_all();
    ext_rst_n    = 1'b1;
    dbg_pin_n    = 1'b1;
    wdt_timeout  = 1'b0;
    dbg_ctl_wr   = 1'b0;
    clr_por_flag = 1'b0;
    clr_wdt_flag = 1'b0;
    clr_ext_flag = 1'b0;
  endtask

  // Steps `cycles` edges; core_rst_n must be 0 after edges lo_first..lo_last
  task automatic watch(input int cycles, input int lo_first, input int lo_last,
                       input bit dbg_follow, input int rel_at, input string req);
    int bad;
    int first_bad;
    logic exp_core;
    logic exp_dbg;
    bad = 0;
    first_bad = -1;
    for (int k = 1; k <= cycles; k++) begin
      step();
      exp_core = !(k >= lo_first && k <= lo_last);
      exp_dbg  = dbg_follow ? exp_core : 1'b1;
      if (core_rst_n !== exp_core || dbg_rst_n !== exp_dbg) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
      if (k == rel_at) release_all();
    end
    chk(req, bad, 0, $sformatf("reset window mismatches (first at edge %0d)", first_bad));
  endtask

  task automatic por_run(input bit xt, input string req);
    int lim;
    lim = xt ? XTAL_C : INT_C;
    step();
    supply_ok = 1'b0;
    xtal_sel  = xt;
    #1;
    chk("R1", int'({core_rst_n, dbg_rst_n, por_flag, wdt_flag, ext_flag, dbg_ctl_bit}), 0,
        "outputs while supply low");
    step();
    step();
    supply_ok = 1'b1;
    for (int k = 1; k <= lim + 2; k++) step();
    chk(req, int'(core_rst_n), 0, "core reset one edge before release");
    chk("R4", int'(por_flag), 0, "power-on flag before release");
    step();
    chk(req, int'(core_rst_n), 1, "core reset at release edge");
    chk(req, int'(dbg_rst_n), 1, "debug reset at release edge");
    chk("R4", int'(por_flag), 1, "power-on flag at release");
    clr_por_flag = 1'b1;
    step();
    clr_por_flag = 1'b0;
    chk("R4", int'(por_flag), 0, "power-on flag after clear");
  endtask

  initial begin
    supply_ok = 1'b0; xtal_sel = 1'b0; mode_stop = 1'b0; wdt_rst_en = 1'b0;
    release_all();

    // R2: internal-oscillator delay
    por_run(1'b0, "R2");

    // R5/R6/R11: external pin width sweep
    for (int n = 1; n <= 7; n++) begin
      ext_rst_n = 1'b0;
      if (n >= 3) watch(n + 25, 6, n + 18, 1'b1, n, "R6");
      else        watch(n + 25, 0, -1, 1'b1, n, "R5");
      chk("R11", int'(ext_flag), (n >= 3) ? 1 : 0, $sformatf("ext flag after %0d-edge pulse", n));
      clr_ext_flag = 1'b1;
      step();
      clr_ext_flag = 1'b0;
      chk("R11", int'(ext_flag), 0, "ext flag after clear");
    end

    // R5: pin accepted in stop mode too
    mode_stop = 1'b1;
    ext_rst_n = 1'b0;
    watch(30, 6, 4 + 18, 1'b1, 4, "R5");
    mode_stop = 1'b0;
    clr_ext_flag = 1'b1; step(); clr_ext_flag = 1'b0;

    // R7/R11: watchdog over mode x enable; set wins over a simultaneous clear
    for (int m = 0; m <= 1; m++) begin
      for (int e = 0; e <= 1; e++) begin
        mode_stop   = m[0];
        wdt_rst_en  = e[0];
        wdt_timeout = 1'b1;
        clr_wdt_flag = 1'b1;
        if (m == 0 && e == 1) watch(22, 1, STR_C, 1'b1, 1, "R7");
        else                  watch(22, 0, -1, 1'b1, 1, "R7");
        chk("R11", int'(wdt_flag), (m == 0 && e == 1) ? 1 : 0,
            $sformatf("wdt flag mode=%0d en=%0d", m, e));
      end
    end
    mode_stop = 1'b0;
    clr_wdt_flag = 1'b1; step(); clr_wdt_flag = 1'b0;
    chk("R11", int'(wdt_flag), 0, "wdt flag after clear");

    // R8: debugger bit in run mode
    dbg_ctl_wr = 1'b1;
    step();
    dbg_ctl_wr = 1'b0;
    chk("R8", int'(dbg_ctl_bit), 1, "control bit after write");
    chk("R8", int'(core_rst_n), 1, "core not yet reset after write edge");
    watch(21, 1, STR_C, 1'b0, 0, "R8");
    chk("R8", int'(dbg_ctl_bit), 0, "control bit self-cleared");

    // R8: pending in stop mode, taken on return to run mode
    mode_stop = 1'b1;
    dbg_ctl_wr = 1'b1;
    step();
    dbg_ctl_wr = 1'b0;
    watch(20, 0, -1, 1'b0, 0, "R8");
    chk("R8", int'(dbg_ctl_bit), 1, "control bit pending in stop mode");
    mode_stop = 1'b0;
    watch(20, 1, STR_C, 1'b0, 0, "R8");
    chk("R8", int'(dbg_ctl_bit), 0, "control bit consumed in run mode");

    // R9: debug pin in stop mode resets both domains, ignored in run mode
    mode_stop = 1'b1;
    for (int n = 2; n <= 5; n++) begin
      dbg_pin_n = 1'b0;
      if (n >= 3) watch(n + 25, 6, n + 18, 1'b1, n, "R9");
      else        watch(n + 25, 0, -1, 1'b1, n, "R9");
    end
    chk("R9", int'(ext_flag), 0, "debug pin does not set ext flag");
    mode_stop = 1'b0;
    dbg_pin_n = 1'b0;
    watch(30, 0, -1, 1'b1, 5, "R9");

    // R10: debugger bit and watchdog on the same edge
    wdt_rst_en = 1'b1;
    dbg_ctl_wr = 1'b1;
    step();
    dbg_ctl_wr = 1'b0;
    wdt_timeout = 1'b1;
    step();
    wdt_timeout = 1'b0;
    chk("R10", int'(dbg_rst_n), 0, "debug reset with overlapping watchdog");
    for (int k = 0; k < 20; k++) step();
    chk("R10", int'(core_rst_n), 1, "released after overlap");

    // R10: watchdog arriving during a debugger reset
    dbg_ctl_wr = 1'b1;
    step();                   // edge 1
    dbg_ctl_wr = 1'b0;
    step(); step(); step();   // edges 2..4
    chk("R10", int'(dbg_rst_n), 1, "debug logic spared before watchdog");
    wdt_timeout = 1'b1;
    step();                   // edge 5
    wdt_timeout = 1'b0;
    chk("R10", int'(dbg_rst_n), 0, "debug reset once watchdog seen");
    for (int k = 6; k <= 20; k++) step();
    chk("R6", int'(core_rst_n), 0, "still held at edge 5+15");
    step();
    chk("R6", int'(core_rst_n), 1, "released at edge 5+16");
    wdt_rst_en = 1'b0;

    // R1/R3: set flags and a pending bit, then crystal power-on
    ext_rst_n = 1'b0;
    watch(30, 6, 4 + 18, 1'b1, 4, "R5");
    mode_stop = 1'b1;
    dbg_ctl_wr = 1'b1;
    step();
    dbg_ctl_wr = 1'b0;
    mode_stop = 1'b0;
    wdt_rst_en = 1'b1;
    wdt_timeout = 1'b1;
    #1;
    supply_ok = 1'b0;
    #1;
    chk("R1", int'({core_rst_n, dbg_rst_n, ext_flag, dbg_ctl_bit}), 0,
        "asynchronous clear between edges");
    wdt_timeout = 1'b0;
    wdt_rst_en = 1'b0;
    por_run(1'b1, "R3");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule